// File: doc/BRIEF.md
# Maskable Interrupt Entry and Return Sequencer

This block is the processor-side logic that takes a maskable interrupt request from the interrupt controller and switches context to the handler. It owns the program counter, the status word, a backup program counter, a backup status word and a cause register. The status word has three control bits: a no-preempt bit (bit 7), an exception-pending bit (bit 6) and an interrupt-disable bit (bit 5). The other status bits are stored but not interpreted.

When a request is accepted, the block runs a fixed five-step entry sequence, one step per clock cycle:
1. Save the return program counter.
2. Save the status word.
3. Write the request's code into the low half of the cause register.
4. Mask further requests.
5. Jump to a vector derived from the code, while pulsing an acknowledge back to the controller.

In idle cycles the surrounding pipeline can drive four operations: a return operation, a status-word write, an enable operation and a disable operation. It can also advance the program counter. A request that arrives while it cannot be taken stays pending at the controller and is taken as soon as the masking bits clear.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows: program counter = RESET_PC (default 0), status word = 0x20 (only the disable bit 5 set), backup program counter, backup status word and cause all 0, and acknowledge low.
- R2: While status bit 7 (no-preempt) or bit 5 (disable) is 1, an asserted request is not accepted. The acknowledge stays low and no register is changed by the request.
- R3: At the clock edge that accepts a request (idle, request high, bits 7 and 5 both 0), the code is captured. On the next edge, the backup program counter takes the program counter value held at acceptance.
- R4: On the second edge after acceptance, the backup status word takes the status word held at acceptance.
- R5: On the third edge after acceptance, cause bits 15:0 take the captured code. Cause bits 31:16 keep their value.
- R6: On the fourth edge after acceptance, status bit 5 is set and bit 6 is cleared. All other status bits keep their value.
- R7: On the fifth edge after acceptance, the program counter becomes VEC_BASE + code × 16 (default VEC_BASE = 0x100).
- R8: The acknowledge is high for exactly one cycle, the cycle between the fourth and fifth edges after acceptance.
- R9: A return operation in an idle, non-accepting cycle loads the program counter from the backup program counter and the status word from the backup status word at one edge.
- R10: A status-word write in an idle, non-accepting cycle loads the written value. A pending request is accepted at the first edge at which the status word (after a return or a write) has bits 7 and 5 both 0.
- R11: An enable operation clears only status bit 5. A disable operation sets only status bit 5. Priority among idle operations is: return, then write, then enable, then disable.
- R12: In an idle, non-accepting cycle with no return operation, a program-counter advance adds 4. Without an advance, the program counter holds.
- R13: Return, write, enable, disable and advance inputs have no effect in the accepting cycle or during the entry sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable request level from the controller |
| irq_code | input | 16 | Code of the requesting source |
| irq_ack | output | 1 | One-cycle acknowledge on the vector step |
| ret_op | input | 1 | Return operation |
| psw_wr | input | 1 | Status-word write strobe |
| psw_wdata | input | 32 | Status-word write data |
| ei_op | input | 1 | Enable operation (clear bit 5) |
| di_op | input | 1 | Disable operation (set bit 5) |
| pc_adv | input | 1 | Advance program counter by 4 |
| pc | output | 32 | Program counter |
| psw | output | 32 | Status word |
| bk_pc | output | 32 | Backup program counter |
| bk_psw | output | 32 | Backup status word |
| cause | output | 32 | Cause register |

## Verification
The bench goes after the edges where acceptance competes with other activity:
- A request held while only the no-preempt bit is set. A design gating acceptance on the disable bit alone would vector early.
- A return issued in the same cycle a request becomes acceptable. A design executing both would corrupt the saved program counter.
- Operations driven during the sequence. A design that honoured them would change the saved status word or the program counter mid-entry.
- The cause upper half and the status bits outside bit 5 and bit 6 are checked for preservation, because a wide write of either register would clobber them.
- A pending request is expected to be taken exactly one edge after a return or a write unmasks it. A design with an extra delay or a lost pending request misses the vector cycle.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

    localparam int XLEN      = 32;
    localparam int CODE_W    = 16;
    localparam int PSW_NP    = 7;
    localparam int PSW_EP    = 6;
    localparam int PSW_ID    = 5;
    localparam int VEC_SHIFT = 4;
    localparam logic [XLEN-1:0] PSW_RESET = XLEN'(1) << PSW_ID;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [CODE_W-1:0] code_t;

    // Entry sequence steps, in order of execution.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SVPC  = 3'd1,
        ST_SVPSW = 3'd2,
        ST_CAUSE = 3'd3,
        ST_MASK  = 3'd4,
        ST_VEC   = 3'd5
    } step_e;

    function automatic word_t vector_addr(input word_t base, input code_t code);
        return base + (word_t'(code) << VEC_SHIFT);
    endfunction

    function automatic word_t psw_on_entry(input word_t p);
        word_t r;
        r         = p;
        r[PSW_ID] = 1'b1;
        r[PSW_EP] = 1'b0;
        return r;
    endfunction

    function automatic word_t cause_merge(input word_t old, input code_t code);
        word_t r;
        r             = old;
        r[CODE_W-1:0] = code;
        return r;
    endfunction

endpackage

// File: rtl/intseq_ctrl.sv
module intseq_ctrl
    import intseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  irq_req,
    input  code_t irq_code,
    input  logic  psw_np,
    input  logic  psw_id,
    output step_e step,
    output code_t code_q,
    output logic  accept,
    output logic  irq_ack
);

    step_e step_n;

    always_comb begin
        accept = (step == ST_IDLE) && irq_req && !psw_np && !psw_id;
        irq_ack = (step == ST_VEC);
    end

    always_comb begin
        step_n = step;
        unique case (step)
            ST_IDLE:  step_n = accept ? ST_SVPC : ST_IDLE;
            ST_SVPC:  step_n = ST_SVPSW;
            ST_SVPSW: step_n = ST_CAUSE;
            ST_CAUSE: step_n = ST_MASK;
            ST_MASK:  step_n = ST_VEC;
            ST_VEC:   step_n = ST_IDLE;
            default:  step_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= ST_IDLE;
            code_q <= '0;
        end else begin
            step <= step_n;
            if (accept) code_q <= irq_code;
        end
    end

    // R2: masked status keeps the sequencer idle
    p_hold_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (step == ST_IDLE && (psw_np || psw_id)) |=> (step == ST_IDLE));

    // R8: acknowledge lasts one cycle
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    // R7: the vector step always returns to idle
    p_vec_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (step == ST_VEC) |=> (step == ST_IDLE));

endmodule

// File: rtl/intseq_psw.sv
module intseq_psw
    import intseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    input  logic  accept,
    input  logic  ret_op,
    input  logic  psw_wr,
    input  word_t psw_wdata,
    input  logic  ei_op,
    input  logic  di_op,
    input  word_t bk_psw,
    output word_t psw
);

    word_t psw_n;
    logic  idle_free;

    always_comb begin
        idle_free = (step == ST_IDLE) && !accept;
        psw_n     = psw;
        if (step == ST_MASK) begin
            psw_n = psw_on_entry(psw);
        end else if (idle_free) begin
            if (ret_op)      psw_n = bk_psw;
            else if (psw_wr) psw_n = psw_wdata;
            else if (ei_op)  psw_n[PSW_ID] = 1'b0;
            else if (di_op)  psw_n[PSW_ID] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) psw <= PSW_RESET;
        else     psw <= psw_n;
    end

    // R6: mask step sets disable and clears exception-pending
    p_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (step == ST_MASK) |=> (psw[PSW_ID] && !psw[PSW_EP]));

    // R13: status word frozen in the accepting cycle and early steps
    p_frozen_r13: assert property (@(posedge clk) disable iff (rst)
        (accept || step == ST_SVPC || step == ST_SVPSW || step == ST_CAUSE)
        |=> $stable(psw));

endmodule

// File: rtl/intseq_regs.sv
module intseq_regs
    import intseq_pkg::*;
#(
    parameter word_t RESET_PC = '0,
    parameter word_t VEC_BASE = 32'h0000_0100,
    parameter word_t PC_STEP  = 32'd4
) (
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    input  logic  accept,
    input  logic  ret_op,
    input  logic  pc_adv,
    input  code_t code_q,
    input  word_t psw,
    output word_t pc,
    output word_t bk_pc,
    output word_t bk_psw,
    output word_t cause
);

    logic idle_free;
    assign idle_free = (step == ST_IDLE) && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= RESET_PC;
            bk_pc  <= '0;
            bk_psw <= '0;
            cause  <= '0;
        end else begin
            unique case (step)
                ST_SVPC:  bk_pc  <= pc;
                ST_SVPSW: bk_psw <= psw;
                ST_CAUSE: cause  <= cause_merge(cause, code_q);
                ST_VEC:   pc     <= vector_addr(VEC_BASE, code_q);
                ST_IDLE: begin
                    if (idle_free) begin
                        if (ret_op)      pc <= bk_pc;
                        else if (pc_adv) pc <= pc + PC_STEP;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: backup PC captures PC on the first step
    p_bkpc_r3: assert property (@(posedge clk) disable iff (rst)
        (step == ST_SVPC) |=> (bk_pc == $past(pc)));

    // R5: cause low half gets the code, upper half kept
    p_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (step == ST_CAUSE) |=> (cause[31:16] == $past(cause[31:16])
                                && cause[15:0] == $past(code_q)));

    // R7: vector step loads the handler address
    p_vector_r7: assert property (@(posedge clk) disable iff (rst)
        (step == ST_VEC) |=> (pc == vector_addr(VEC_BASE, $past(code_q))));

    // R9: return restores PC from backup
    p_ret_r9: assert property (@(posedge clk) disable iff (rst)
        (idle_free && ret_op) |=> (pc == $past(bk_pc)));

    // R13: PC does not move in the accepting cycle
    p_pc_hold_r13: assert property (@(posedge clk) disable iff (rst)
        accept |=> $stable(pc));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import intseq_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] VEC_BASE = 32'h0000_0100,
    parameter logic [31:0] PC_STEP  = 32'd4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_req,
    input  logic [15:0] irq_code,
    output logic        irq_ack,
    input  logic        ret_op,
    input  logic        psw_wr,
    input  logic [31:0] psw_wdata,
    input  logic        ei_op,
    input  logic        di_op,
    input  logic        pc_adv,
    output logic [31:0] pc,
    output logic [31:0] psw,
    output logic [31:0] bk_pc,
    output logic [31:0] bk_psw,
    output logic [31:0] cause
);

    step_e step;
    code_t code_q;
    logic  accept;

    intseq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .irq_req  (irq_req),
        .irq_code (irq_code),
        .psw_np   (psw[PSW_NP]),
        .psw_id   (psw[PSW_ID]),
        .step     (step),
        .code_q   (code_q),
        .accept   (accept),
        .irq_ack  (irq_ack)
    );

    intseq_psw u_psw (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .accept    (accept),
        .ret_op    (ret_op),
        .psw_wr    (psw_wr),
        .psw_wdata (psw_wdata),
        .ei_op     (ei_op),
        .di_op     (di_op),
        .bk_psw    (bk_psw),
        .psw       (psw)
    );

    intseq_regs #(
        .RESET_PC (RESET_PC),
        .VEC_BASE (VEC_BASE),
        .PC_STEP  (PC_STEP)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .accept (accept),
        .ret_op (ret_op),
        .pc_adv (pc_adv),
        .code_q (code_q),
        .psw    (psw),
        .pc     (pc),
        .bk_pc  (bk_pc),
        .bk_psw (bk_psw),
        .cause  (cause)
    );

    // R4: backup status word captures the status word on the second step
    p_bkpsw_r4: assert property (@(posedge clk) disable iff (rst)
        (step == ST_SVPSW) |=> (bk_psw == $past(psw)));

    // R8: acknowledge only on the cycle the PC is redirected
    p_ack_vec_r8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (pc == VEC_BASE + ({16'h0, $past(code_q)} << 4)));

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

    localparam logic [31:0] VB  = 32'h0000_0100;
    localparam logic [31:0] RPC = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [15:0] irq_code = '0;
    logic        irq_ack;
    logic        ret_op = 1'b0, psw_wr = 1'b0, ei_op = 1'b0, di_op = 1'b0, pc_adv = 1'b0;
    logic [31:0] psw_wdata = '0;
    logic [31:0] pc, psw, bk_pc, bk_psw, cause;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_pc, m_psw, m_bkpc, m_bkpsw, m_cause;
    logic [15:0] m_code;
    int          m_step;
    int          m_last;

    always #4 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_code(irq_code), .irq_ack(irq_ack),
        .ret_op(ret_op), .psw_wr(psw_wr), .psw_wdata(psw_wdata), .ei_op(ei_op),
        .di_op(di_op), .pc_adv(pc_adv), .pc(pc), .psw(psw), .bk_pc(bk_pc),
        .bk_psw(bk_psw), .cause(cause)
    );

    function automatic logic [31:0] exp_vector(input logic [15:0] c);
        return VB + {12'h0, c, 4'h0};
    endfunction

    task automatic model_reset();
        m_pc = RPC; m_psw = 32'h20; m_bkpc = '0; m_bkpsw = '0; m_cause = '0;
        m_code = '0; m_step = 0; m_last = 0;
    endtask

    task automatic model_step();
        m_last = m_step;
        case (m_step)
            0: begin
                if (irq_req && !m_psw[7] && !m_psw[5]) begin
                    m_code = irq_code;
                    m_step = 1;
                end else begin
                    if (ret_op) begin
                        m_pc = m_bkpc; m_psw = m_bkpsw;
                    end else begin
                        if (psw_wr)     m_psw = psw_wdata;
                        else if (ei_op) m_psw[5] = 1'b0;
                        else if (di_op) m_psw[5] = 1'b1;
                        if (pc_adv)     m_pc = m_pc + 32'd4;
                    end
                end
            end
            1: begin m_bkpc = m_pc; m_step = 2; end
            2: begin m_bkpsw = m_psw; m_step = 3; end
            3: begin m_cause[15:0] = m_code; m_step = 4; end
            4: begin m_psw[5] = 1'b1; m_psw[6] = 1'b0; m_step = 5; end
            default: begin m_pc = exp_vector(m_code); m_step = 0; end
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        string t;
        t = tag;
        if (t == "") begin
            case (m_last)
                1: t = "R3";
                2: t = "R4";
                3: t = "R5";
                4: t = "R6";
                5: t = "R7";
                default: t = "R12";
            endcase
        end
        check(t, "pc", pc, m_pc);
        check(t, "psw", psw, m_psw);
        check(t, "bk_pc", bk_pc, m_bkpc);
        check(t, "bk_psw", bk_psw, m_bkpsw);
        check(t, "cause", cause, m_cause);
        check(t, "ack", {31'h0, irq_ack}, {31'h0, m_step == 5});
    endtask

    task automatic drive(input logic req, input logic [15:0] code, input logic ret,
                         input logic wr, input logic [31:0] wd, input logic ei,
                         input logic di, input logic adv, input string tag);
        irq_req = req; irq_code = code; ret_op = ret; psw_wr = wr; psw_wdata = wd;
        ei_op = ei; di_op = di; pc_adv = adv;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // R2: disable bit set after reset, request held
        for (int i = 0; i < 3; i++) drive(1, 16'd3, 0, 0, 0, 0, 0, 1, "R2");
        // only no-preempt set
        drive(0, 16'd3, 0, 1, 32'h0000_00C0, 0, 0, 1, "R10");
        for (int i = 0; i < 3; i++) drive(1, 16'd3, 0, 0, 0, 0, 0, 0, "R2");
        // write clears both mask bits, EP kept set
        drive(1, 16'd5, 0, 1, 32'hA500_0040, 0, 0, 0, "R10");
        // accepting edge
        drive(1, 16'd5, 0, 0, 0, 0, 0, 0, "R10");
        drive(0, 16'd0, 0, 0, 0, 0, 0, 0, "R3");
        drive(0, 16'd0, 0, 0, 0, 0, 0, 0, "R4");
        drive(0, 16'd0, 0, 0, 0, 0, 0, 0, "R5");
        drive(0, 16'd0, 0, 0, 0, 0, 0, 0, "R6");
        check("R8", "ack_on_vec_cycle", {31'h0, irq_ack}, 32'd1);
        drive(0, 16'd0, 0, 0, 0, 0, 0, 0, "R7");
        check("R7", "vector", pc, VB + 32'h50);
        check("R6", "psw_entry", psw, 32'hA500_0020);
        check("R8", "ack_dropped", {31'h0, irq_ack}, 32'd0);
        drive(0, 16'd0, 0, 0, 0, 0, 0, 1, "R12");
        check("R12", "advance", pc, VB + 32'h54);

        // R11: enable and disable touch only bit 5
        drive(0, 16'd0, 0, 0, 0, 1, 0, 0, "R11");
        drive(0, 16'd0, 0, 0, 0, 0, 1, 0, "R11");
        drive(0, 16'd0, 0, 0, 0, 1, 1, 0, "R11");
        // R13: request accepted together with return: return ignored
        drive(1, 16'h00FF, 1, 1, 32'hFFFF_FFFF, 0, 1, 1, "R13");
        for (int i = 0; i < 5; i++) drive(0, 16'd0, 1, 1, 32'hFFFF_FFFF, 1, 1, 1, "R13");
        check("R7", "vector_noise", pc, VB + 32'h0FF0);

        // R2 then R10: pending request with disable set, released by return
        for (int i = 0; i < 2; i++) drive(1, 16'd9, 0, 0, 0, 0, 0, 1, "R2");
        drive(1, 16'd9, 1, 0, 0, 0, 0, 0, "R9");
        drive(1, 16'd9, 0, 0, 0, 0, 0, 0, "R10");
        for (int i = 0; i < 5; i++) drive(0, 16'd0, 0, 0, 0, 0, 0, 0, "");
        drive(0, 16'd0, 1, 0, 0, 0, 0, 0, "R9");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            wd = $urandom();
            if ($urandom_range(0, 1) == 0) wd[7] = 1'b0;
            if ($urandom_range(0, 1) == 0) wd[5] = 1'b0;
            drive($urandom_range(0, 9) < 3,
                  16'($urandom_range(0, 255)),
                  $urandom_range(0, 9) == 0,
                  $urandom_range(0, 9) == 0,
                  wd,
                  $urandom_range(0, 9) == 0,
                  $urandom_range(0, 19) == 0,
                  $urandom_range(0, 1) == 1,
                  "");
        end
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule